// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs read and write cycles on an asynchronous external memory or peripheral bus for one address region. A CPU-side request carries a region offset, a size code (byte, halfword or word), a direction and write data. The block splits the request into 8-bit or 16-bit bus beats and drives active-low chip select, read strobe and write strobe. It enables and releases the data drivers and steps the address between beats. For reads, it packs the sampled bus data into a 32-bit result.

The cycle shape comes from two configuration words held outside the block. The first is a per-region delay/size word: strobe widths, phase enables, bus width, address stepping and window size. The second is a common word whose four nibbles give the lengths of the optional phases. An offset that falls outside the configured window raises a sticky error flag and produces no bus activity.

Top module: `xbus_seq`

## Requirements
- R1: During and straight after reset: `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are high, `bus_doe`, `rsp_valid` and `err_flag` are low, and `req_ready` is high.
- R2: A write strobe stays low for w+1 cycles and a read strobe for r+1 cycles. Here w is `cfg_word[3:0]` and r is `cfg_word[7:4]`. The two strobes are never low together.
- R3: Chip select falls exactly one cycle before the first strobe and stays low into every later strobe. The address is presented from the cycle after acceptance. When `cfg_word[11]` is set, `com_word[15:12]` extra cycles with chip select high are added before chip select falls.
- R4: Bus width comes from `cfg_word[12]` (0 = 8 bits, 1 = 16 bits). Size codes are 0 = byte, 1 = halfword, and 2 or 3 = word. A request runs ceil(bytes / bus bytes) beats, with one strobe pulse per beat. Strobes go high for exactly one cycle between beats, and chip select stays low from before the first strobe until after the last.
- R5: When `cfg_word[13]` is set, the bus address advances by the bus width in bytes (1 or 2) after each beat. When it is clear, every beat uses the request offset.
- R6: Write data leaves least significant part first. On an 8-bit bus, beat k drives byte k on `bus_dout[7:0]` with `bus_dout[15:8]` zero. On a 16-bit bus, beat k drives halfword k.
- R7: Read beat k lands in byte lane k (8-bit bus, from `bus_din[7:0]`) or halfword lane k (16-bit bus). It is sampled in the last strobe-low cycle. Bits above the request size read as zero.
- R8: When `cfg_word[9]` is set, a write keeps chip select low and the data driven for `com_word[7:4]` cycles after the last write strobe rises. `bus_doe` is high whenever the write strobe is low.
- R9: When `cfg_word[10]` is set, a read keeps chip select low for `com_word[11:8]` cycles after the last read strobe rises. `bus_doe` stays low for the whole read.
- R10: When `cfg_word[8]` is set, `req_ready` stays low for `com_word[3:0]` cycles after the cycle in which chip select rises. Otherwise it returns in the next cycle.
- R11: `rsp_valid` is a one-cycle pulse in the cycle chip select rises, carrying `rsp_rdata` for reads. It comes P + B·(S+2) + T + 2 cycles after acceptance, where P is the pre-strobe length, B the beat count, S the strobe field and T the hold or float length.
- R12: With N = `cfg_word[20:16]`, a request whose offset is 2^N or more sets `err_flag`. It runs no bus cycle, gives no response, and leaves `req_ready` high. Only the start offset is checked.
- R13: `err_clr` high clears `err_flag` in the next cycle. If an out-of-window request arrives in the same cycle, the flag is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 32 | Region delay/size word |
| com_word | input | 16 | Common phase-length word |
| err_clr | input | 1 | Clears the window error flag |
| err_flag | output | 1 | Sticky window error |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_addr | input | ADDR_W | Region offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Assembled read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | 16 | Data toward the bus |
| bus_doe | output | 1 | Data driver enable |
| bus_din | input | 16 | Data from the bus |

## Verification
The sweep crosses bus width, address stepping, every size code, both directions, strobe widths and four phase-enable mixes. It compares each beat's address, data, strobe width and the overall latency with arithmetic expectations. A sequencer that dropped chip select between beats would show several chip-select rises per access. One that read the wrong strobe field, or added a phase on the wrong direction, would show a wrong pulse width or latency. Swapped lanes, or a missing zero-fill, would appear in `rsp_rdata`. The window edge is probed at 2^N-1 and at 2^N, and so is a clear that coincides with a new error; an off-by-one compare or the wrong priority shows up in the flag.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
// Shared types for the external bus sequencer.
// Assumes a 32-bit request data path and a bus of up to 16 bits.
package xbus_pkg;

    localparam int XB_DATA_W = 32;
    localparam int XB_BUS_W  = 16;
    localparam int XB_DLY_W  = 4;
    localparam int XB_WIN_W  = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_LEAD, ST_STRB, ST_GAP, ST_TAIL, ST_DONE, ST_RECV
    } seq_state_t;

    // Timing fields held for the length of one access.
    typedef struct packed {
        logic [XB_DLY_W-1:0] wr_dly;
        logic [XB_DLY_W-1:0] rd_dly;
        logic [XB_DLY_W-1:0] hold_len;
        logic [XB_DLY_W-1:0] flt_len;
        logic [XB_DLY_W-1:0] rec_len;
        logic                wide;
        logic                autoinc;
    } bus_timing_t;

    // Number of bus beats minus one for a size code and bus width.
    function automatic logic [1:0] beats_m1(input logic [1:0] size, input logic wide);
        case (size)
            2'd0:    return 2'd0;
            2'd1:    return wide ? 2'd0 : 2'd1;
            default: return wide ? 2'd1 : 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/xbus_cfg_dec.sv
`timescale 1ns/1ps
// Decodes the region delay/size word and the common word into phase
// lengths. A disabled phase gets length zero. Assumes both words are
// stable while a request is being accepted.
module xbus_cfg_dec
    import xbus_pkg::*;
(
    input  logic [31:0]         cfg_word,
    input  logic [15:0]         com_word,
    output bus_timing_t         timing,
    output logic [XB_DLY_W-1:0] pre_len,
    output logic [XB_WIN_W-1:0] win_log2
);

    logic unused_cfg_bits;

    // Field extraction and phase gating.
    always_comb begin
        timing.wr_dly   = cfg_word[3:0];
        timing.rd_dly   = cfg_word[7:4];
        timing.rec_len  = cfg_word[8]  ? com_word[3:0]   : '0;
        timing.hold_len = cfg_word[9]  ? com_word[7:4]   : '0;
        timing.flt_len  = cfg_word[10] ? com_word[11:8]  : '0;
        pre_len         = cfg_word[11] ? com_word[15:12] : '0;
        timing.wide     = cfg_word[12];
        timing.autoinc  = cfg_word[13];
        win_log2        = cfg_word[20:16];
    end

    assign unused_cfg_bits = ^{cfg_word[31:21], cfg_word[15:14]};

endmodule

// File: rtl/xbus_win_chk.sv
`timescale 1ns/1ps
// Flags an offset at or beyond a window of 2^N bytes: any set address
// bit at position N or above. N at or above ADDR_W never flags.
module xbus_win_chk
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [XB_WIN_W-1:0] win_log2,
    output logic                out_of_win
);

    logic [ADDR_W-1:0] hit;

    // One compare per address bit.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign hit[i] = addr[i] && (i >= int'(win_log2));
    end

    assign out_of_win = |hit;

endmodule

// File: rtl/xbus_lane.sv
`timescale 1ns/1ps
// Lane steering: picks the write byte or halfword for the current beat
// and packs sampled read data into its lane. Little-endian beat order.
// Lanes above the request size stay zero after clear.
module xbus_lane
    import xbus_pkg::*;
#(
    parameter int DATA_W = XB_DATA_W,
    parameter int BUS_W  = XB_BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cap_en,
    input  logic              wide,
    input  logic [1:0]        size,
    input  logic [1:0]        beat_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BUS_W-1:0]  bus_din,
    output logic [BUS_W-1:0]  bus_dout,
    output logic [DATA_W-1:0] rdata
);

    localparam int NBYTE  = DATA_W / 8;
    localparam int HALF_B = BUS_W / 8;
    localparam int BIDX_W = $clog2(NBYTE);

    logic [3:0] size_bytes;

    // Bytes covered by the request size.
    always_comb begin
        case (size)
            2'd0:    size_bytes = 4'd1;
            2'd1:    size_bytes = 4'd2;
            default: size_bytes = 4'(NBYTE);
        endcase
    end

    // Write lane for the current beat.
    always_comb begin
        if (wide) begin
            bus_dout = BUS_W'(wdata >> (int'(beat_idx) * BUS_W));
        end else begin
            bus_dout = {{(BUS_W-8){1'b0}}, wdata[8*int'(beat_idx) +: 8]};
        end
    end

    for (genvar j = 0; j < NBYTE; j++) begin : g_byte
        logic       lane_hit;
        logic [7:0] lane_src;

        assign lane_hit = (wide ? (beat_idx == BIDX_W'(j / HALF_B))
                                : (beat_idx == BIDX_W'(j)))
                          && (j < int'(size_bytes));
        assign lane_src = wide ? bus_din[8*(j % HALF_B) +: 8] : bus_din[7:0];

        // Capture register for byte lane j.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[8*j +: 8] <= '0;
            end else if (clear) begin
                rdata[8*j +: 8] <= '0;
            end else if (cap_en && lane_hit) begin
                rdata[8*j +: 8] <= lane_src;
            end
        end
    end

endmodule

// File: rtl/xbus_seq.sv
`timescale 1ns/1ps
// External bus cycle sequencer for one region.
// Per access: address phase (1 + optional pre-strobe cycles, CS high),
// one lead cycle with CS low, then per beat a strobe of delay+1 cycles
// with a one-cycle gap between beats, an optional hold (write) or
// float (read) tail, a done cycle with CS high and a response pulse,
// then optional recovery before the next request is taken.
// Assumes cfg_word/com_word are valid in the accepting cycle; their
// fields are held internally for the rest of the access.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          cfg_word,
    input  logic [15:0]          com_word,
    input  logic                 err_clr,
    output logic                 err_flag,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [1:0]           req_size,
    input  logic                 req_write,
    input  logic [XB_DATA_W-1:0] req_wdata,
    output logic                 rsp_valid,
    output logic [XB_DATA_W-1:0] rsp_rdata,
    output logic                 bus_cs_n,
    output logic                 bus_rd_n,
    output logic                 bus_wr_n,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [XB_BUS_W-1:0]  bus_dout,
    output logic                 bus_doe,
    input  logic [XB_BUS_W-1:0]  bus_din
);

    localparam int CNT_W = XB_DLY_W;

    bus_timing_t           tm_live, tm_q;
    logic [CNT_W-1:0]      pre_live;
    logic [XB_WIN_W-1:0]   win_log2;
    logic                  win_bad;

    seq_state_t            state, state_n;
    logic [CNT_W-1:0]      cnt, cnt_n;
    logic [1:0]            beat_q, nbeat_m1_q, size_q;
    logic                  write_q;
    logic [XB_DATA_W-1:0]  wdata_q;
    logic [ADDR_W-1:0]     addr_q;
    logic                  err_q;
    logic                  cs_n_q, rd_n_q, wr_n_q, doe_q;

    logic                  acc, good_req, bad_req;
    logic                  last_beat, beat_end, write_nx;
    logic [CNT_W-1:0]      strobe_len, tail_len;

    xbus_cfg_dec u_dec (
        .cfg_word (cfg_word),
        .com_word (com_word),
        .timing   (tm_live),
        .pre_len  (pre_live),
        .win_log2 (win_log2)
    );

    xbus_win_chk #(.ADDR_W(ADDR_W)) u_win (
        .addr       (req_addr),
        .win_log2   (win_log2),
        .out_of_win (win_bad)
    );

    assign acc        = (state == ST_IDLE) && req_valid;
    assign good_req   = acc && !win_bad;
    assign bad_req    = acc && win_bad;
    assign last_beat  = (beat_q == nbeat_m1_q);
    assign beat_end   = (state == ST_STRB) && (cnt == '0);
    assign strobe_len = write_q ? tm_q.wr_dly : tm_q.rd_dly;
    assign tail_len   = write_q ? tm_q.hold_len : tm_q.flt_len;
    assign write_nx   = good_req ? req_write : write_q;

    // Next-state and phase counter logic.
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        case (state)
            ST_IDLE: begin
                if (good_req) begin
                    state_n = ST_ADDR;
                    cnt_n   = pre_live;
                end
            end
            ST_ADDR: begin
                if (cnt == '0) state_n = ST_LEAD;
                else           cnt_n   = cnt - 1'b1;
            end
            ST_LEAD: begin
                state_n = ST_STRB;
                cnt_n   = strobe_len;
            end
            ST_STRB: begin
                if (cnt != '0) begin
                    cnt_n = cnt - 1'b1;
                end else if (!last_beat) begin
                    state_n = ST_GAP;
                end else if (tail_len == '0) begin
                    state_n = ST_DONE;
                end else begin
                    state_n = ST_TAIL;
                    cnt_n   = tail_len - 1'b1;
                end
            end
            ST_GAP: begin
                state_n = ST_STRB;
                cnt_n   = strobe_len;
            end
            ST_TAIL: begin
                if (cnt == '0) state_n = ST_DONE;
                else           cnt_n   = cnt - 1'b1;
            end
            ST_DONE: begin
                if (tm_q.rec_len == '0) begin
                    state_n = ST_IDLE;
                end else begin
                    state_n = ST_RECV;
                    cnt_n   = tm_q.rec_len - 1'b1;
                end
            end
            ST_RECV: begin
                if (cnt == '0) state_n = ST_IDLE;
                else           cnt_n   = cnt - 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Request capture and beat/address progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q       <= '0;
            size_q     <= '0;
            write_q    <= 1'b0;
            wdata_q    <= '0;
            addr_q     <= '0;
            beat_q     <= '0;
            nbeat_m1_q <= '0;
        end else if (good_req) begin
            tm_q       <= tm_live;
            size_q     <= req_size;
            write_q    <= req_write;
            wdata_q    <= req_wdata;
            addr_q     <= req_addr;
            beat_q     <= '0;
            nbeat_m1_q <= beats_m1(req_size, tm_live.wide);
        end else if (beat_end && !last_beat) begin
            beat_q <= beat_q + 1'b1;
            if (tm_q.autoinc) begin
                addr_q <= addr_q + ADDR_W'(tm_q.wide ? 2 : 1);
            end
        end
    end

    // Sticky window error; a new error wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (bad_req) err_q <= 1'b1;
        else if (err_clr) err_q <= 1'b0;
    end

    // Registered bus control pins, decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            rd_n_q <= 1'b1;
            wr_n_q <= 1'b1;
            doe_q  <= 1'b0;
        end else begin
            cs_n_q <= !(state_n inside {ST_LEAD, ST_STRB, ST_GAP, ST_TAIL});
            rd_n_q <= !((state_n == ST_STRB) && !write_q);
            wr_n_q <= !((state_n == ST_STRB) && write_q);
            doe_q  <= write_nx
                      && (state_n inside {ST_ADDR, ST_LEAD, ST_STRB, ST_GAP, ST_TAIL});
        end
    end

    xbus_lane #(.DATA_W(XB_DATA_W), .BUS_W(XB_BUS_W)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (good_req),
        .cap_en   (beat_end && !write_q),
        .wide     (tm_q.wide),
        .size     (size_q),
        .beat_idx (beat_q),
        .wdata    (wdata_q),
        .bus_din  (bus_din),
        .bus_dout (bus_dout),
        .rdata    (rsp_rdata)
    );

    assign req_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_DONE);
    assign err_flag  = err_q;
    assign bus_cs_n  = cs_n_q;
    assign bus_rd_n  = rd_n_q;
    assign bus_wr_n  = wr_n_q;
    assign bus_doe   = doe_q;
    assign bus_addr  = addr_q;

    // Strobes never overlap (R2).
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    // Chip select already low in the cycle before a strobe falls (R3).
    p_cs_leads_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> !$past(bus_cs_n));

    // A strobe only appears inside chip select (R4).
    p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);

    // Data driven while writing (R8).
    p_wr_drives_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> bus_doe);

    // Bus released while reading (R9).
    p_rd_floats_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_doe);

    // Response is a single pulse, in the cycle chip select rises (R11).
    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_rsp_at_cs_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(bus_cs_n));

    // Out-of-window request: flag set, no bus cycle, still ready (R12).
    p_err_no_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && win_bad) |=> (err_flag && bus_cs_n && req_ready));

    // Clear without a competing error empties the flag (R13).
    p_err_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(req_valid && req_ready && win_bad)) |=> !err_flag);

endmodule

// File: tb/test_xbus_seq.sv
`timescale 1ns/1ps
module test_xbus_seq;

    localparam int    ADDR_W = 16;
    localparam logic [15:0] COM = 16'h2132; // c0=2 c1=3 c2=1 c3=2

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       cfg_word = '0;
    logic [15:0]       com_word = COM;
    logic              err_clr = 1'b0;
    logic              err_flag;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = '0;
    logic              req_write = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              bus_cs_n, bus_rd_n, bus_wr_n, bus_doe;
    logic [ADDR_W-1:0] bus_addr;
    logic [15:0]       bus_dout, bus_din;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] din_of(input logic [15:0] a);
        return {~a[7:0], a[7:0] + 8'h3C};
    endfunction

    assign bus_din = din_of(bus_addr);

    xbus_seq #(.ADDR_W(ADDR_W)) i_xbus_seq (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .com_word(com_word),
        .err_clr(err_clr), .err_flag(err_flag),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din)
    );

    // Bus monitor, sampled at the falling edge; cumulative counters only.
    int          stb_total = 0, cs_low_total = 0, nostb_total = 0, doe_nostb_total = 0;
    int          doe_total = 0, cs_rise_total = 0, lead_bad_total = 0, rsp_total = 0;
    int          cur_len = 0;
    logic [15:0] a_arr [64];
    logic [15:0] d_arr [64];
    int          len_arr [64];
    logic        prev_cs_n = 1'b1, prev_stb = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!bus_cs_n) cs_low_total++;
            if (!bus_cs_n && bus_rd_n && bus_wr_n) begin
                nostb_total++;
                if (bus_doe) doe_nostb_total++;
            end
            if (bus_doe) doe_total++;
            if (rsp_valid) rsp_total++;
            if (!(bus_rd_n && bus_wr_n) && !prev_stb) begin
                if (prev_cs_n) lead_bad_total++;
                a_arr[stb_total % 64] = bus_addr;
                d_arr[stb_total % 64] = bus_dout;
                stb_total++;
                cur_len = 1;
            end else if (!(bus_rd_n && bus_wr_n)) begin
                cur_len++;
            end
            if ((bus_rd_n && bus_wr_n) && prev_stb) len_arr[(stb_total - 1) % 64] = cur_len;
            if (bus_cs_n && !prev_cs_n) cs_rise_total++;
        end
        prev_cs_n = bus_cs_n;
        prev_stb  = !(bus_rd_n && bus_wr_n);
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input int wd, input int rd, input int rec,
                                           input int hold, input int flt, input int pre,
                                           input int wide, input int inc, input int n);
        return 32'(wd) | (32'(rd) << 4) | (32'(rec) << 8) | (32'(hold) << 9)
             | (32'(flt) << 10) | (32'(pre) << 11) | (32'(wide) << 12)
             | (32'(inc) << 13) | (32'(n) << 16);
    endfunction

    // One complete access with all waveform and data checks.
    task automatic run_access(input int wide, input int inc, input int size, input int wr,
                              input int pre, input int hold, input int flt, input int rec,
                              input int wd, input int rd, input int n,
                              input logic [15:0] addr, input logic [31:0] wdata);
        int s0, c0, ns0, dn0, dt0, r0, lb0;
        int nb, wb, d, p, t, r, lat, csf, k, idx;
        logic [31:0] exp_rd;
        logic [15:0] a, v;
        nb = (size == 0) ? 1 : (size == 1) ? (wide ? 1 : 2) : (wide ? 2 : 4);
        wb = wide ? 2 : 1;
        d  = wr ? wd : rd;
        p  = pre ? 2 : 0;
        t  = wr ? (hold ? 3 : 0) : (flt ? 1 : 0);
        r  = rec ? 2 : 0;
        cfg_word  = mk_cfg(wd, rd, rec, hold, flt, pre, wide, inc, n);
        req_addr  = addr;
        req_size  = 2'(size);
        req_write = wr[0];
        req_wdata = wdata;
        s0 = stb_total; c0 = cs_low_total; ns0 = nostb_total; dn0 = doe_nostb_total;
        dt0 = doe_total; r0 = cs_rise_total; lb0 = lead_bad_total;
        check("R10 ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        lat = 0; csf = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) req_valid = 1'b0;
            if (csf == 0 && !bus_cs_n) csf = lat;
        end while (!rsp_valid && lat < 600);
        check("R11 response latency", 32'(lat), 32'(p + nb * (d + 2) + t + 2));
        check("R3 chip-select fall cycle", 32'(csf), 32'(p + 2));
        check("R12 no error in window", 32'(err_flag), 32'd0);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!req_ready && k < 100);
        check("R10 recovery length", 32'(k), 32'(r + 1));
        check("R4 strobe count", 32'(stb_total - s0), 32'(nb));
        check("R4 one chip-select rise", 32'(cs_rise_total - r0), 32'd1);
        check("R3 lead cycle before strobes", 32'(lead_bad_total - lb0), 32'd0);
        check("R4 chip-select low cycles", 32'(cs_low_total - c0), 32'(nb * (d + 2) + t));
        check("R8 R9 non-strobe cycles in select", 32'(nostb_total - ns0), 32'(nb + t));
        if (wr != 0) begin
            check("R8 data held in select", 32'(doe_nostb_total - dn0), 32'(nb + t));
        end else begin
            check("R9 read never drives", 32'(doe_total - dt0), 32'd0);
        end
        exp_rd = '0;
        for (int b = 0; b < nb; b++) begin
            idx = (s0 + b) % 64;
            a   = addr + ((inc != 0) ? 16'(b * wb) : 16'd0);
            check("R2 strobe width", 32'(len_arr[idx]), 32'(d + 1));
            check("R5 beat address", 32'(a_arr[idx]), 32'(a));
            if (wr != 0) begin
                if (wide != 0) check("R6 write halfword", 32'(d_arr[idx]), 32'(wdata[16*b +: 16]));
                else           check("R6 write byte", 32'(d_arr[idx]), 32'(wdata[8*b +: 8]));
            end
            v = din_of(a);
            if (wide != 0) exp_rd[16*b +: 16] = v;
            else           exp_rd[8*b +: 8]   = v[7:0];
        end
        if (size == 0) exp_rd &= 32'h0000_00FF;
        if (size == 1) exp_rd &= 32'h0000_FFFF;
        if (wr == 0) check("R7 read assembly", rsp_rdata, exp_rd);
    endtask

    // Out-of-window request; optional simultaneous clear.
    task automatic bad_access(input int n, input logic [15:0] addr, input logic with_clr);
        int c0, q0;
        cfg_word  = mk_cfg(1, 1, 0, 0, 0, 0, 0, 1, n);
        req_addr  = addr;
        req_size  = 2'd2;
        req_write = 1'b0;
        c0 = cs_low_total; q0 = rsp_total;
        req_valid = 1'b1;
        err_clr   = with_clr;
        @(negedge clk);
        req_valid = 1'b0;
        err_clr   = 1'b0;
        check("R12 R13 error flag set", 32'(err_flag), 32'd1);
        check("R12 ready after error", 32'(req_ready), 32'd1);
        repeat (6) @(negedge clk);
        check("R12 no chip select on error", 32'(cs_low_total - c0), 32'd0);
        check("R12 no response on error", 32'(rsp_total - q0), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 cs_n", 32'(bus_cs_n), 32'd1);
        check("R1 rd_n", 32'(bus_rd_n), 32'd1);
        check("R1 wr_n", 32'(bus_wr_n), 32'd1);
        check("R1 doe",  32'(bus_doe), 32'd0);
        check("R1 rsp",  32'(rsp_valid), 32'd0);
        check("R1 err",  32'(err_flag), 32'd0);
        check("R1 ready", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 32'({bus_cs_n, bus_doe, req_ready}), 32'b101);

        // Sweep of width, stepping, size, direction, phase mix, delays.
        for (int wide = 0; wide < 2; wide++)
            for (int inc = 0; inc < 2; inc++)
                for (int size = 0; size < 3; size++)
                    for (int wr = 0; wr < 2; wr++)
                        for (int ph = 0; ph < 4; ph++)
                            for (int dl = 0; dl < 2; dl++) begin
                                automatic int pre_h = (ph == 1 || ph == 2) ? 1 : 0;
                                automatic int flt_r = (ph == 1 || ph == 3) ? 1 : 0;
                                run_access(wide, inc, size, wr, pre_h, pre_h, flt_r, flt_r,
                                           dl ? 2 : 0, dl ? 3 : 1, 16,
                                           16'h0040 + 16'(ph * 37 + size * 5 + dl * 3),
                                           32'hA1B2C3D4 ^ 32'(ph * 32'h01010101 + wr));
                            end

        // Window edges: last byte inside, first byte outside.
        run_access(0, 1, 2, 0, 0, 0, 0, 0, 0, 0, 4, 16'h000F, 32'h0);
        bad_access(4, 16'h0010, 1'b0);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R13 clear empties flag", 32'(err_flag), 32'd0);
        bad_access(4, 16'h0010, 1'b1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        check("R13 clear after set-wins", 32'(err_flag), 32'd0);
        run_access(1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 16'h0000, 32'h5A);
        bad_access(0, 16'h0001, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end

endmodule